// File: doc/BRIEF.md
# Gated Seconds Counter Clock

This block keeps time as a 32-bit count of seconds, held in two 16-bit halves, and adds a third 16-bit register whose bit 0 decides whether software may change the count. A free-running prescaler divides the system clock by `TICK_DIV` to make a one-cycle tick once per second. Each tick adds one to the low half. When the low half rolls over to zero, the high half also advances. Each half wraps at 2^16.

Software reaches the registers over a 64-bit bus. The bus carries a word address and an 8-bit byte mask. Each 64-bit word holds two 32-bit register slots. The mask selects the slot: any set bit in `bus_mask[7:4]` selects the upper slot. Both 16-bit and 32-bit accesses are served, and only the low 16 bits of the chosen slot are used. Writes to either half of the count take effect only while the enable bit is 1. An accepted write to the low half also restarts the one-second phase from that clock edge.

Read responses are sequenced by a two-state machine. `RSP_IDLE` moves to `RSP_DATA` on a read request (transition *read_issue*). `RSP_DATA` stays in `RSP_DATA` on a back-to-back read (*read_chain*). Otherwise `RSP_DATA` returns to `RSP_IDLE` (*read_done*). `RSP_IDLE` stays in `RSP_IDLE` when there is no read (*idle_hold*). Writes complete in the cycle they are presented, in either state.

Top module: `rtc_seconds_top`

## Requirements
- R1: The register is chosen from the word address and the slot. Address 0, lower slot (any mask with `bus_mask[7:4]`=0) selects the high half. Address 0, upper slot selects the low half. Address 1, lower slot selects the enable register. Any other combination reads as zero, and writes to it change nothing.
- R2: Each register stores only bits [15:0] of the selected slot, so a 32-bit write drops bits [31:16]. A read returns the register zero-extended within its slot, and the other slot reads as zero.
- R3: The enable register keeps only written bit 0, and its bits [15:1] always read as zero.
- R4: While enable bit 0 is 0, writes to the high half and to the low half are discarded, and the old values stay.
- R5: While enable bit 0 is 1, a write to the low half stores the value and restarts the prescaler. The first increment afterwards happens at the `TICK_DIV`-th rising edge after the write edge.
- R6: On every tick the low half increments modulo 2^16. On the tick where it wraps to zero, the high half increments modulo 2^16.
- R7: A tick on the same edge as an accepted low-half write is lost, and the written value is kept. A tick on the same edge as an accepted high-half write still increments the low half, and the high half takes the written value.
- R8: Reset clears all three registers and the prescaler. The first increment happens at the `TICK_DIV`-th rising edge after reset is released.
- R9: A read request sampled at an edge drives `rd_valid` high for the following cycle. The data returned are the register values as they stood before that edge. `rd_valid` is low in every cycle after an edge with no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, sampled each rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | 64-bit word address |
| bus_mask | input | 8 | Byte mask; upper nibble selects the upper slot |
| bus_wdata | input | 64 | Write data, positioned in the selected slot |
| rd_valid | output | 1 | Read data valid this cycle |
| rd_data | output | 64 | Read data, placed in the slot that was addressed |

## Verification
The count is driven in four ways, and each separates a different fault:
- Quiet running tells a wrong divide ratio from a correct one.
- Writes with the enable bit clear tell a missing gate apart from a working one.
- A low-half write followed by reads on every cycle pins the restarted phase to the exact edge. This also catches a prescaler that is not cleared.
- Writes placed on the very edge of a tick separate the required write-over-tick priority from an increment that leaks through.

Separately, 32-bit writes with junk in the upper bits, and accesses to the unused slot, show whether lane selection and truncation are correct. A behavioural model in the bench predicts every read response, and the bench compares against it on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        SEL_HIGH = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } rtc_sel_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_DATA = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 64
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BUS_W/8-1:0] mask,
    input  logic [BUS_W-1:0]   wdata,
    output rtc_sel_e           sel,
    output logic               upper_slot,
    output logic [REG_W-1:0]   wval
);
    localparam int MASK_W = BUS_W / 8;
    localparam int SLOT_W = BUS_W / 2;

    always_comb begin
        upper_slot = |mask[MASK_W-1:MASK_W/2];
        wval       = upper_slot ? wdata[SLOT_W +: REG_W] : wdata[0 +: REG_W];
        unique case (1'b1)
            (addr == ADDR_W'(0)): sel = upper_slot ? SEL_LOW : SEL_HIGH;
            (addr == ADDR_W'(1)): sel = upper_slot ? SEL_NONE : SEL_CTRL;
            default:              sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    output logic                tick,
    output logic [((TICK_DIV > 1) ? $clog2(TICK_DIV) : 1)-1:0] phase
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    assign tick = (phase == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (restart || tick)
            phase <= '0;
        else
            phase <= phase + CW'(1);
    end
endmodule

// File: rtl/rtc_count_regs.sv
module rtc_count_regs
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rtc_sel_e         sel,
    input  logic [REG_W-1:0] wval,
    input  logic             tick,
    output logic [REG_W-1:0] high_q,
    output logic [REG_W-1:0] low_q,
    output logic [REG_W-1:0] ctrl_q,
    output logic             low_take
);
    logic high_take;
    logic low_wrap;

    assign low_take  = wr_en && (sel == SEL_LOW)  && ctrl_q[0];
    assign high_take = wr_en && (sel == SEL_HIGH) && ctrl_q[0];
    assign low_wrap  = tick && !low_take && (low_q == {REG_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (low_take) begin
            low_q <= wval;
        end else if (tick) begin
            low_q <= low_q + REG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_q <= '0;
        end else if (high_take) begin
            high_q <= wval;
        end else if (low_wrap) begin
            high_q <= high_q + REG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (sel == SEL_CTRL)) begin
            ctrl_q <= {{(REG_W-1){1'b0}}, wval[0]};
        end
    end
endmodule

// File: rtl/rtc_seconds_top.sv
module rtc_seconds_top
    import rtc_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_mask,
    input  logic [63:0]       bus_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data
);
    localparam int BUS_W  = 64;
    localparam int SLOT_W = BUS_W / 2;
    localparam int PH_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    rtc_sel_e         sel;
    logic             upper_slot;
    logic [REG_W-1:0] wval;
    logic             tick;
    logic [PH_W-1:0]  phase;
    logic [REG_W-1:0] high_q, low_q, ctrl_q;
    logic             low_take;
    logic             wr_en, rd_req;
    logic [REG_W-1:0] sel_val;
    rsp_state_e       state_q, state_d;

    assign wr_en  = bus_req && bus_we;
    assign rd_req = bus_req && !bus_we;

    rtc_bus_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
        .addr(bus_addr), .mask(bus_mask), .wdata(bus_wdata),
        .sel(sel), .upper_slot(upper_slot), .wval(wval)
    );

    rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(low_take),
        .tick(tick), .phase(phase)
    );

    rtc_count_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wval(wval),
        .tick(tick), .high_q(high_q), .low_q(low_q), .ctrl_q(ctrl_q),
        .low_take(low_take)
    );

    always_comb begin
        unique case (sel)
            SEL_HIGH: sel_val = high_q;
            SEL_LOW:  sel_val = low_q;
            SEL_CTRL: sel_val = ctrl_q;
            SEL_NONE: sel_val = '0;
        endcase
    end

    // next-state logic of the response sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = rd_req ? RSP_DATA : RSP_IDLE;
            RSP_DATA: state_d = rd_req ? RSP_DATA : RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // output process
    assign rd_valid = (state_q == RSP_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= upper_slot
                ? {{(SLOT_W-REG_W){1'b0}}, sel_val, {SLOT_W{1'b0}}}
                : {{(BUS_W-REG_W){1'b0}}, sel_val};
        end
    end
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk #(
    parameter int W  = 16,
    parameter int PW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic [1:0]    sel,
    input logic [W-1:0]  wval,
    input logic          tick,
    input logic [PW-1:0] phase,
    input logic [W-1:0]  high_q,
    input logic [W-1:0]  low_q,
    input logic [W-1:0]  ctrl_q,
    input logic          rd_valid
);
    logic wr;
    assign wr = bus_req && bus_we;

    p_ctrl_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd2) |=> (ctrl_q == {{(W-1){1'b0}}, $past(wval[0])}));

    p_low_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1 && !ctrl_q[0] && !tick) |=> (low_q == $past(low_q)));

    p_high_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd0 && !ctrl_q[0] && !(tick && low_q == {W{1'b1}}))
        |=> (high_q == $past(high_q)));

    p_low_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1 && ctrl_q[0]) |=> (phase == '0));

    p_low_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1 && ctrl_q[0]) |=> (low_q == $past(wval)));

    p_wrap_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && low_q == {W{1'b1}} && !(wr && sel[1] == 1'b0))
        |=> (low_q == '0 && high_q == $past(high_q) + W'(1)));

    p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> rd_valid);

    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !rd_valid);
endmodule

bind rtc_seconds_top rtc_seconds_chk #(.W(REG_W), .PW(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .sel(sel), .wval(wval), .tick(tick), .phase(phase),
    .high_q(high_q), .low_q(low_q), .ctrl_q(ctrl_q), .rd_valid(rd_valid)
);

// File: tb/sim_rtc_seconds_top.sv
module sim_rtc_seconds_top;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_mask = '0;
    logic [63:0] bus_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rtc_seconds_top #(.TICK_DIV(DIV), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_mask(bus_mask), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_hi, m_lo, m_ctrl, m_ph;
    bit exp_valid;
    logic [63:0] exp_data;
    int exp_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_ctrl = 0; m_ph = 0; exp_valid = 0; exp_data = '0;
        end else begin
            bit up, tk, lo_ok, hi_ok;
            int idx, v, old_lo, rv;
            up = (bus_mask[7:4] != 4'h0);
            if (bus_addr == 4'd0) idx = up ? 1 : 0;
            else if (bus_addr == 4'd1) idx = up ? 3 : 2;
            else idx = 3;
            v = up ? int'(bus_wdata[47:32]) : int'(bus_wdata[15:0]);
            tk = (m_ph == DIV - 1);
            lo_ok = bus_req && bus_we && idx == 1 && m_ctrl == 1;
            hi_ok = bus_req && bus_we && idx == 0 && m_ctrl == 1;
            old_lo = m_lo;
            rv = (idx == 0) ? m_hi : (idx == 1) ? m_lo : (idx == 2) ? m_ctrl : 0;
            exp_valid = bus_req && !bus_we;
            if (exp_valid) begin
                exp_idx = idx;
                exp_data = up ? (64'(rv) << 32) : 64'(rv);
            end
            if (lo_ok) m_lo = v;
            else if (tk) m_lo = (m_lo + 1) % 65536;
            if (hi_ok) m_hi = v;
            else if (tk && !lo_ok && old_lo == 65535) m_hi = (m_hi + 1) % 65536;
            if (bus_req && bus_we && idx == 2) m_ctrl = v & 1;
            if (lo_ok || tk) m_ph = 0; else m_ph = m_ph + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(rd_valid == exp_valid, "R9 rd_valid", 64'(rd_valid), 64'(exp_valid));
            if (exp_valid)
                check(rd_data == exp_data,
                      (exp_idx == 2) ? "R3 model ctrl" : (exp_idx == 3) ? "R1 model none" : "R6 model count",
                      rd_data, exp_data);
        end
    end

    // register handles: 0 high, 1 low, 2 ctrl, 3 unused
    task automatic bus_write(input int r, input logic [31:0] v, input bit wide);
        bit up;
        up = r[0];
        bus_addr  = (r >= 2) ? 4'd1 : 4'd0;
        bus_mask  = wide ? (up ? 8'hF0 : 8'h0F) : (up ? 8'h30 : 8'h03);
        bus_wdata = up ? {v, 32'h0} : {32'h0, v};
        bus_we = 1'b1; bus_req = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int r, output logic [63:0] d);
        bus_addr = (r >= 2) ? 4'd1 : 4'd0;
        bus_mask = r[0] ? 8'h30 : 8'h03;
        bus_we = 1'b0; bus_req = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0;
        d = rd_data;
    endtask

    task automatic expect_reg(input int r, input int val, input string tag);
        logic [63:0] d, e;
        bus_read(r, d);
        e = r[0] ? (64'(val) << 32) : 64'(val);
        check(d == e, tag, d, e);
    endtask

    task automatic wait_tick_edge();
        while (m_ph != DIV - 1) @(negedge clk);
    endtask

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_reg(0, 0, "R8 reset high");
        expect_reg(1, 0, "R8 reset low");
        expect_reg(2, 0, "R8 reset ctrl");
        bus_write(1, 32'h0000_55AA, 1'b1);
        expect_reg(1, 0, "R4 low blocked");
        bus_write(0, 32'h0000_1111, 1'b0);
        expect_reg(0, 0, "R4 high blocked");
        @(negedge clk);
        expect_reg(1, 1, "R8 first tick at edge TICK_DIV");
        bus_write(2, 32'hFFFF_FFFF, 1'b1);
        expect_reg(2, 1, "R3 ctrl bit0 only");
        bus_write(3, 32'h0000_FFFF, 1'b0);
        expect_reg(3, 0, "R1 unused slot");
        bus_write(1, 32'hABCD_0100, 1'b1);
        for (int k = 1; k <= DIV + 1; k++)
            expect_reg(1, (k <= DIV) ? 32'h100 : 32'h101, "R5 restart timing / R2 truncation");
        bus_write(0, 32'h0000_1234, 1'b0);
        bus_write(1, 32'h0000_FFFF, 1'b0);
        repeat (DIV + 1) @(negedge clk);
        expect_reg(1, 0, "R6 low wraps");
        expect_reg(0, 32'h1235, "R6 carry into high");
        bus_write(0, 32'h0000_FFFF, 1'b1);
        bus_write(1, 32'h0000_FFFF, 1'b1);
        repeat (DIV + 1) @(negedge clk);
        expect_reg(0, 0, "R6 high wraps");
        wait_tick_edge();
        bus_write(1, 32'h0000_0500, 1'b0);
        expect_reg(1, 32'h500, "R7 tick lost to low write");
        wait_tick_edge();
        bus_write(0, 32'h0000_0777, 1'b0);
        expect_reg(1, 32'h501, "R7 low still ticks");
        expect_reg(0, 32'h777, "R7 high takes write");
        bus_write(2, 32'h0000_0000, 1'b0);
        bus_write(1, 32'h0000_9999, 1'b0);
        bus_read(1, d);
        check(d[47:32] != 16'h9999, "R4 low blocked after clear", d, 64'h0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end
endmodule